// File: doc/BRIEF.md
# Charge and Discharge Status Flag Generator

This block builds the secondary status byte of a battery monitor. A charge-count pulse stream and a charge-start event drive a fast-charge flag. The flag is forced high when charging begins. It is then kept high only while each one-second window holds enough charge pulses. A signed sense-resistor voltage, given in millivolts and qualified by a valid strobe, is sorted into a discharge-rate code and an overload flag.

The overload flag also gates a sampling-enable output for end-of-discharge detection. This enable drops at once when overload is seen. It comes back only after a half-second quiet period once overload has cleared. If overload comes back during that period, the period starts again. The fast-charge flag is also brought out as an efficiency-factor select. A read port returns the packed byte at its register address.

Top module: `chg_dis_status`

## Requirements
- R1: After reset, the status byte reads 00h, `fast_sel` is 0 and `eod_smp_en` is 1.
- R2: Reading address 06h returns the fast-charge flag in bit 7, the discharge-rate code in bits 6:4 and the overload flag in bit 0, with bits 3:1 at zero. Any other address reads 00h.
- R3: A cycle with `chg_start` high sets the fast-charge flag at that clock edge.
- R4: The fast-charge flag stays 1 across a one-second window (CLK_HZ cycles, counted from the charge start) that holds at least FAST_MIN_CNT charge pulses. This includes the case of exactly FAST_MIN_CNT pulses.
- R5: The fast-charge flag clears at the edge that closes a window holding fewer than FAST_MIN_CNT pulses. With no pulses, that is the CLK_HZ-th edge after the starting edge.
- R6: `fast_sel` is 1 (fast-charge factors) when the fast-charge flag is 1, and 0 (trickle factors) when it is 0.
- R7: On a valid sample, the discharge-rate code becomes 001 if the voltage is below DR_TH_MV (-150 mV). It becomes 000 if the voltage is at or above that threshold.
- R8: On a valid sample, the overload flag becomes 1 if the voltage is below OVLD_TH_MV (-250 mV). It becomes 0 if the voltage is at or above that threshold.
- R9: `eod_smp_en` is 0 in every cycle where the overload flag is 1.
- R10: After the edge that clears overload, `eod_smp_en` stays 0 for CLK_HZ/2 - 1 more cycles. It returns to 1 after the (CLK_HZ/2)-th edge.
- R11: If overload comes back during the hold-off, the hold-off restarts in full from the next clearing edge.
- R12: Voltage values presented while `sns_vld` is 0 change neither the code nor the overload flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sns_mv | input | SNS_W | Signed sense voltage in millivolts |
| sns_vld | input | 1 | Sense sample valid strobe |
| chg_pulse | input | 1 | One-cycle charge-count pulse |
| chg_start | input | 1 | Charge action start event |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data |
| fast_sel | output | 1 | Efficiency select: 1 fast, 0 trickle |
| eod_smp_en | output | 1 | End-of-discharge sampling enable |

## Verification
The bench builds the block with CLK_HZ set to 20. This makes a one-second window 20 cycles long and the hold-off 10 cycles long. The exact edges at which the fast-charge flag drops and the sampling enable returns can therefore be checked cycle by cycle. Voltage boundaries are probed at the threshold itself and one millivolt below it. The pulse patterns give exactly the minimum count, one short of it, and a steady surplus.

// File: rtl/stat2_pkg.sv
package stat2_pkg;
  localparam logic [7:0] STAT2_ADDR = 8'h06;
  localparam int CR_BIT   = 7;
  localparam int DR_LSB   = 4;
  localparam int OVLD_BIT = 0;

  typedef enum logic [2:0] {
    DR_BAND0 = 3'b000,
    DR_BAND1 = 3'b001
  } dr_band_e;

  function automatic logic [7:0] pack_stat2(input logic cr, input dr_band_e dr, input logic ov);
    logic [7:0] b;
    b = '0;
    b[CR_BIT] = cr;
    b[DR_LSB +: 3] = dr;
    b[OVLD_BIT] = ov;
    return b;
  endfunction
endpackage

// File: rtl/chg_rate_flag.sv
module chg_rate_flag #(
  parameter int TICKS   = 1000000,
  parameter int MIN_CNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_start,
  input  logic chg_pulse,
  output logic fast_q
);
  localparam int TW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam int CW = $clog2(MIN_CNT + 1);

  logic [TW-1:0] sec_q, sec_d;
  logic [CW-1:0] pc_q, pc_d, pc_inc;
  logic          fast_d, win_end, pc_sat;

  always_comb begin
    win_end = (sec_q == TW'(TICKS - 1));
    pc_sat  = (pc_q == CW'(MIN_CNT));
    pc_inc  = pc_q + CW'(chg_pulse && !pc_sat);
    sec_d   = sec_q + TW'(1);
    pc_d    = pc_inc;
    fast_d  = fast_q;
    if (chg_start) begin
      sec_d  = '0;
      pc_d   = '0;
      fast_d = 1'b1;
    end else if (win_end) begin
      sec_d = '0;
      pc_d  = '0;
      if (pc_inc < CW'(MIN_CNT)) fast_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      pc_q   <= '0;
      fast_q <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      pc_q   <= pc_d;
      fast_q <= fast_d;
    end
  end
endmodule

// File: rtl/sense_bands.sv
module sense_bands
  import stat2_pkg::*;
#(
  parameter int SNS_W      = 16,
  parameter int DR_TH_MV   = -150,
  parameter int OVLD_TH_MV = -250
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SNS_W-1:0] sns_mv,
  input  logic                    sns_vld,
  output dr_band_e                dr_q,
  output logic                    ovld_q,
  output logic                    ovld_nxt
);
  localparam logic signed [SNS_W-1:0] DR_TH = SNS_W'(DR_TH_MV);
  localparam logic signed [SNS_W-1:0] OV_TH = SNS_W'(OVLD_TH_MV);

  dr_band_e dr_d;

  always_comb begin
    dr_d     = dr_q;
    ovld_nxt = ovld_q;
    if (sns_vld) begin
      dr_d     = (sns_mv < DR_TH) ? DR_BAND1 : DR_BAND0;
      ovld_nxt = (sns_mv < OV_TH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= DR_BAND0;
      ovld_q <= 1'b0;
    end else begin
      dr_q   <= dr_d;
      ovld_q <= ovld_nxt;
    end
  end
endmodule

// File: rtl/eod_holdoff.sv
module eod_holdoff #(
  parameter int HOLD_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovld_q,
  input  logic ovld_nxt,
  output logic smp_en
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ovld_q && !ovld_nxt)  cnt_d = HW'(HOLD_CYC);
    else if (ovld_q)          cnt_d = '0;
    else if (cnt_q != '0)     cnt_d = cnt_q - HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign smp_en = !ovld_q && (cnt_q == '0);
endmodule

// File: rtl/chg_dis_status.sv
module chg_dis_status
  import stat2_pkg::*;
#(
  parameter int CLK_HZ       = 1000000,
  parameter int SNS_W        = 16,
  parameter int ADDR_W       = 8,
  parameter int FAST_MIN_CNT = 2,
  parameter int DR_TH_MV     = -150,
  parameter int OVLD_TH_MV   = -250
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SNS_W-1:0] sns_mv,
  input  logic                    sns_vld,
  input  logic                    chg_pulse,
  input  logic                    chg_start,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic                    fast_sel,
  output logic                    eod_smp_en
);
  localparam int HOLD_CYC = CLK_HZ / 2;

  logic [1:0] rs_q;
  logic       rst_sync_n;
  logic       cr_flag, ovld_flag, ovld_nxt;
  dr_band_e   dr_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  chg_rate_flag #(.TICKS(CLK_HZ), .MIN_CNT(FAST_MIN_CNT)) u_rate (
    .clk(clk), .rst_n(rst_sync_n), .chg_start(chg_start),
    .chg_pulse(chg_pulse), .fast_q(cr_flag)
  );

  sense_bands #(.SNS_W(SNS_W), .DR_TH_MV(DR_TH_MV), .OVLD_TH_MV(OVLD_TH_MV)) u_bands (
    .clk(clk), .rst_n(rst_sync_n), .sns_mv(sns_mv), .sns_vld(sns_vld),
    .dr_q(dr_code), .ovld_q(ovld_flag), .ovld_nxt(ovld_nxt)
  );

  eod_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .ovld_q(ovld_flag),
    .ovld_nxt(ovld_nxt), .smp_en(eod_smp_en)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(STAT2_ADDR)) rd_data = pack_stat2(cr_flag, dr_code, ovld_flag);
  end

  assign fast_sel = cr_flag;
endmodule

// File: rtl/chg_dis_status_chk.sv
module chg_dis_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chg_start,
  input logic       sns_vld,
  input logic       fast_q,
  input logic [2:0] dr_q,
  input logic       ovld_q,
  input logic       eod_smp_en
);
  p_start_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chg_start |=> fast_q);

  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_q) |-> $past(chg_start));

  p_ovld_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovld_q |-> (dr_q == 3'b001));

  p_eod_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovld_q |-> !eod_smp_en);

  p_holdoff_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovld_q) |-> !eod_smp_en);

  p_eod_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eod_smp_en) |-> (!ovld_q && $past(!ovld_q)));

  p_no_vld_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sns_vld |=> ($stable(dr_q) && $stable(ovld_q)));
endmodule

bind chg_dis_status chg_dis_status_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .chg_start(chg_start), .sns_vld(sns_vld),
  .fast_q(cr_flag), .dr_q(dr_code), .ovld_q(ovld_flag), .eod_smp_en(eod_smp_en)
);

// File: tb/chg_dis_status_tb.sv
`timescale 1ns/1ps
module chg_dis_status_tb;
  localparam int HZ   = 20;
  localparam int HOLD = HZ / 2;

  logic               clk;
  logic               rst_n;
  logic signed [15:0] sns_mv;
  logic               sns_vld, chg_pulse, chg_start;
  logic [7:0]         rd_addr, rd_data;
  logic               fast_sel, eod_smp_en;
  int n_chk, n_err;

  chg_dis_status #(.CLK_HZ(HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .sns_mv(sns_mv), .sns_vld(sns_vld),
    .chg_pulse(chg_pulse), .chg_start(chg_start), .rd_addr(rd_addr),
    .rd_data(rd_data), .fast_sel(fast_sel), .eod_smp_en(eod_smp_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
    rd_addr = 8'h06;
  endtask

  task automatic put_sample(input logic signed [15:0] mv);
    sns_mv  = mv;
    sns_vld = 1'b1;
    @(negedge clk);
    sns_vld = 1'b0;
  endtask

  task automatic start_charge();
    chg_start = 1'b1;
    @(negedge clk);
    chg_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h06, d);
    chk("R1 byte after reset", d, 8'h00);
    chk("R1 fast_sel after reset", fast_sel, 1'b0);
    chk("R1 eod_smp_en after reset", eod_smp_en, 1'b1);
  endtask

  task automatic t_no_pulses();
    logic [7:0] d;
    start_charge();
    rd(8'h06, d);
    chk("R3 flag set on start", d[7], 1'b1);
    chk("R6 fast_sel high", fast_sel, 1'b1);
    repeat (HZ - 1) @(negedge clk);
    chk("R5 flag before window end", fast_sel, 1'b1);
    @(negedge clk);
    rd(8'h06, d);
    chk("R5 flag cleared at window end", d[7], 1'b0);
    chk("R6 fast_sel low", fast_sel, 1'b0);
  endtask

  task automatic t_pulses(input int npulse, input logic exp_flag, input string tag);
    start_charge();
    for (int c = 1; c <= HZ; c++) begin
      chg_pulse = (c % 5 == 0) && (c / 5 <= npulse);
      @(negedge clk);
    end
    chg_pulse = 1'b0;
    chk(tag, fast_sel, exp_flag);
    repeat (HZ) @(negedge clk);
    chk("R5 no pulses in second window", fast_sel, 1'b0);
  endtask

  task automatic t_steady();
    start_charge();
    for (int c = 1; c <= 3 * HZ; c++) begin
      chg_pulse = (c % 5 == 0);
      @(negedge clk);
    end
    chg_pulse = 1'b0;
    chk("R4 steady pulse stream keeps fast", fast_sel, 1'b1);
    repeat (2 * HZ + 2) @(negedge clk);
    chk("R5 stream stopped clears fast", fast_sel, 1'b0);
  endtask

  task automatic t_bands();
    logic [7:0] d;
    put_sample(-16'sd150);
    rd(8'h06, d);
    chk("R7 -150 gives code 000", d[6:4], 3'b000);
    put_sample(-16'sd151);
    rd(8'h06, d);
    chk("R7 -151 gives code 001", d[6:4], 3'b001);
    put_sample(-16'sd250);
    rd(8'h06, d);
    chk("R8 -250 no overload", d[0], 1'b0);
    chk("R2 layout code only", d, 8'h10);
    put_sample(-16'sd251);
    rd(8'h06, d);
    chk("R8 -251 overload", d[0], 1'b1);
    chk("R2 layout code and overload", d, 8'h11);
    rd(8'h05, d);
    chk("R2 other address reads zero", d, 8'h00);
    sns_mv = 16'sd100;
    repeat (5) @(negedge clk);
    rd(8'h06, d);
    chk("R12 unstrobed sample ignored", d, 8'h11);
    chk("R9 enable low in overload", eod_smp_en, 1'b0);
    put_sample(16'sd20);
    rd(8'h06, d);
    chk("R7 positive clears code", d, 8'h00);
    repeat (HOLD + 2) @(negedge clk);
  endtask

  task automatic t_layout_fast();
    logic [7:0] d;
    put_sample(-16'sd300);
    start_charge();
    rd(8'h06, d);
    chk("R2 all fields set", d, 8'h91);
    put_sample(16'sd0);
    repeat (HZ + HOLD) @(negedge clk);
  endtask

  task automatic t_holdoff();
    put_sample(-16'sd400);
    chk("R9 enable low on overload", eod_smp_en, 1'b0);
    repeat (6) @(negedge clk);
    chk("R9 enable stays low", eod_smp_en, 1'b0);
    put_sample(16'sd0);
    chk("R10 low at clearing edge", eod_smp_en, 1'b0);
    repeat (HOLD - 1) @(negedge clk);
    chk("R10 low one cycle before end", eod_smp_en, 1'b0);
    @(negedge clk);
    chk("R10 enable back after hold-off", eod_smp_en, 1'b1);
  endtask

  task automatic t_restart();
    put_sample(-16'sd400);
    put_sample(16'sd0);
    repeat (3) @(negedge clk);
    chk("R11 in hold-off", eod_smp_en, 1'b0);
    put_sample(-16'sd300);
    chk("R11 overload again", eod_smp_en, 1'b0);
    put_sample(-16'sd10);
    repeat (HOLD - 1) @(negedge clk);
    chk("R11 full hold-off restarted", eod_smp_en, 1'b0);
    @(negedge clk);
    chk("R11 enable after restarted hold-off", eod_smp_en, 1'b1);
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    sns_mv = '0;
    sns_vld = 1'b0;
    chg_pulse = 1'b0;
    chg_start = 1'b0;
    rd_addr = 8'h06;
    @(negedge clk);
    t_reset();
    t_no_pulses();
    t_pulses(2, 1'b1, "R4 exactly two pulses keeps fast");
    t_pulses(1, 1'b0, "R5 one pulse clears fast");
    t_steady();
    t_bands();
    t_layout_fast();
    t_holdoff();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule